// File: doc/BRIEF.md
# Fast-Page-Mode DRAM Strobe Controller

This block sits between a simple synchronous host port and an asynchronous DRAM with a 4-bit data path and multiplexed row/column address pins. It turns each host request into one complete random-access cycle on the memory pins: the row address and the row strobe, then the column address and the column strobe, then a precharge gap. A read returns one data word to the host, marked by a one-cycle valid flag.

The controller owns every timing rule of the memory, with each interval given as a parameter in clock cycles. After reset it keeps the strobes idle for a long power-up pause. It then issues eight column-before-row refresh cycles and only afterwards opens the host port. During operation a timer spaces refreshes evenly over the retention period. A refresh due at a cycle boundary wins over a waiting host request. A sideband input can hold periodic refresh back. If the time since the last refresh ever reaches the retention limit, the controller runs the eight-cycle wake-up again before it serves the host. A parameter selects the write style: either the write strobe falls before the column strobe, or it falls after it with the output enable held off.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: From reset release, row and column strobes stay high and `req_ready` stays low for at least `PAUSE_CYC` clock cycles.
- R2: After the pause, exactly eight refresh cycles run before `req_ready` is first asserted.
- R3: In every refresh cycle the column strobe falls while the row strobe is high, the row strobe falls afterwards while the column strobe is low, and the write strobe stays high throughout.
- R4: With `LATE_WRITE`=0, a write has the write strobe already low when the column strobe falls, drives the data bus (`dram_dq_oe`=1) from the row phase to the end of the column strobe, and keeps output enable high.
- R5: With `LATE_WRITE`=1, a write has the write strobe high when the column strobe falls and pulls it low while the column strobe is low. Output enable is high in any cycle where the write strobe is low, and the data bus is never driven while output enable is low.
- R6: A read holds the write strobe high until both strobes are high again, drives output enable low while the column strobe is low, and pulses `rsp_valid` for exactly one cycle per read.
- R7: Periodic refreshes are spaced by `REF_INTERVAL` cycles, and a due refresh starts before a waiting host request. Under continuous traffic, no gap between refreshes exceeds the interval plus one access and one refresh.
- R8: When `REF_LIMIT` cycles pass without a refresh, the controller drops `req_ready` and runs exactly eight refresh cycles before serving the host again, even while `ref_inhibit` is high.
- R9: `req_addr` holds the row in its upper `ADDR_W` bits and the column in its lower bits. The row is on `dram_addr` when the row strobe falls, and the column is on `dram_addr` when the column strobe falls. The row strobe stays high for at least `T_RP` cycles between falls.
- R10: `req_ready` is high only when the controller is idle after initialisation, with both strobes high. A read returns the data last written to that address.
- R11: While `ref_inhibit` is high, periodic refreshes are deferred and `req_ready` stays high when the controller is idle. When the inhibit is released, the deferred refresh runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this cycle when valid is also high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*ADDR_W | Row in upper half, column in lower half |
| req_wdata | input | DQ_W | Write data |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | DQ_W | Read data |
| ref_inhibit | input | 1 | Defer periodic refresh |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | ADDR_W | Multiplexed row/column address |
| dram_dq_out | output | DQ_W | Data driven to the memory |
| dram_dq_oe | output | 1 | Data bus drive enable |
| dram_dq_in | input | DQ_W | Data from the memory |

## Verification
A corrupted phase or timer register shows at the strobe pins within one cycle as a misordered edge. Examples are a column strobe falling with the write strobe in the wrong level, a refresh with the write strobe low, or a precharge that is too short; the memory model flags each of these at that edge. A wrong wake-up or refresh count shows as a refresh total that differs from eight when `req_ready` returns, or as a refresh gap longer than the interval bound within one interval. A wrong latched address or data word stays hidden until that location is read back. It then shows as a mismatched nibble or as a row/column capture that differs from the request.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
    typedef enum logic [3:0] {
        S_PAUSE, S_IDLE, S_ROW, S_RCD, S_COL, S_CAS, S_CBRC, S_CBRR, S_PRE
    } phase_e;

    typedef enum logic [1:0] {OP_RD, OP_WR, OP_RF} op_e;
endpackage

// File: rtl/fpm_ref_timer.sv
module fpm_ref_timer #(
    parameter int REF_INTERVAL = 195,
    parameter int REF_LIMIT    = 800000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic ref_start,
    output logic due,
    output logic overrun
);
    localparam int IVL_W = $clog2(REF_INTERVAL + 1);
    localparam int GAP_W = $clog2(REF_LIMIT + 1);

    typedef struct packed {
        logic [IVL_W-1:0] ivl;
        logic [GAP_W-1:0] gap;
        logic             due;
    } tmr_t;

    tmr_t q, d;
    logic wrap;

    always_comb begin
        d    = q;
        wrap = (q.ivl == IVL_W'(REF_INTERVAL - 1));
        if (clear) begin
            d = '0;
        end else begin
            d.ivl = wrap ? '0 : q.ivl + 1'b1;
            d.due = (q.due & ~ref_start) | wrap;
            if (ref_start)
                d.gap = '0;
            else if (q.gap != GAP_W'(REF_LIMIT))
                d.gap = q.gap + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign due     = q.due;
    assign overrun = (q.gap == GAP_W'(REF_LIMIT));
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
    import fpm_pkg::*;
#(
    parameter int ADDR_W       = 10,
    parameter int DQ_W         = 4,
    parameter int PAUSE_CYC    = 5000,
    parameter int WAKE_N       = 8,
    parameter int T_RCD        = 2,
    parameter int T_CAS        = 3,
    parameter int T_RP         = 3,
    parameter int T_CSR        = 1,
    parameter int T_RAS        = 4,
    parameter int REF_INTERVAL = 195,
    parameter int REF_LIMIT    = 800000,
    parameter bit LATE_WRITE   = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [2*ADDR_W-1:0]   req_addr,
    input  logic [DQ_W-1:0]       req_wdata,
    output logic                  rsp_valid,
    output logic [DQ_W-1:0]       rsp_rdata,
    input  logic                  ref_inhibit,
    output logic                  dram_ras_n,
    output logic                  dram_cas_n,
    output logic                  dram_we_n,
    output logic                  dram_oe_n,
    output logic [ADDR_W-1:0]     dram_addr,
    output logic [DQ_W-1:0]       dram_dq_out,
    output logic                  dram_dq_oe,
    input  logic [DQ_W-1:0]       dram_dq_in
);
    localparam int TMR_W = $clog2(PAUSE_CYC + T_RCD + T_CAS + T_RP + T_CSR + T_RAS + 1);
    localparam int WK_W  = $clog2(WAKE_N + 1);

    typedef struct packed {
        phase_e            ph;
        op_e               op;
        logic [TMR_W-1:0]  tmr;
        logic [WK_W-1:0]   wake;
        logic [ADDR_W-1:0] row;
        logic [ADDR_W-1:0] col;
        logic [DQ_W-1:0]   wdata;
        logic [DQ_W-1:0]   rdata;
        logic              rsp;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
        logic [ADDR_W-1:0] addr;
    } ctl_t;

    ctl_t q, d;
    logic ref_start, ref_due, ref_over, ref_go;

    fpm_ref_timer #(
        .REF_INTERVAL (REF_INTERVAL),
        .REF_LIMIT    (REF_LIMIT)
    ) u_ref_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (q.ph == S_PAUSE),
        .ref_start (ref_start),
        .due       (ref_due),
        .overrun   (ref_over)
    );

    assign ref_go    = ref_due && !ref_inhibit;
    assign req_ready = (q.ph == S_IDLE) && (q.wake == '0) && !ref_over && !ref_go;

    always_comb begin
        d         = q;
        d.rsp     = 1'b0;
        ref_start = 1'b0;
        unique case (q.ph)
            S_PAUSE: begin
                if (q.tmr == '0) d.ph = S_IDLE;
                else             d.tmr = q.tmr - 1'b1;
            end
            S_IDLE: begin
                if (q.wake != '0 || ref_over || ref_go) begin
                    if (q.wake != '0)  d.wake = q.wake - 1'b1;
                    else if (ref_over) d.wake = WK_W'(WAKE_N - 1);
                    d.ph      = S_CBRC;
                    d.op      = OP_RF;
                    d.tmr     = TMR_W'(T_CSR - 1);
                    ref_start = 1'b1;
                end else if (req_valid) begin
                    d.ph    = S_ROW;
                    d.op    = req_write ? OP_WR : OP_RD;
                    d.row   = req_addr[2*ADDR_W-1:ADDR_W];
                    d.col   = req_addr[ADDR_W-1:0];
                    d.wdata = req_wdata;
                end
            end
            S_ROW: begin
                d.ph  = S_RCD;
                d.tmr = TMR_W'(T_RCD - 1);
            end
            S_RCD: begin
                if (q.tmr == '0) d.ph = S_COL;
                else             d.tmr = q.tmr - 1'b1;
            end
            S_COL: begin
                d.ph  = S_CAS;
                d.tmr = TMR_W'(T_CAS - 1);
            end
            S_CAS: begin
                if (q.tmr == '0) begin
                    if (q.op == OP_RD) begin
                        d.rsp   = 1'b1;
                        d.rdata = dram_dq_in;
                    end
                    d.ph  = S_PRE;
                    d.tmr = TMR_W'(T_RP - 1);
                end else begin
                    d.tmr = q.tmr - 1'b1;
                end
            end
            S_CBRC: begin
                if (q.tmr == '0) begin
                    d.ph  = S_CBRR;
                    d.tmr = TMR_W'(T_RAS - 1);
                end else begin
                    d.tmr = q.tmr - 1'b1;
                end
            end
            S_CBRR: begin
                if (q.tmr == '0) begin
                    d.ph  = S_PRE;
                    d.tmr = TMR_W'(T_RP - 1);
                end else begin
                    d.tmr = q.tmr - 1'b1;
                end
            end
            S_PRE: begin
                if (q.tmr == '0) d.ph = S_IDLE;
                else             d.tmr = q.tmr - 1'b1;
            end
            default: d.ph = S_IDLE;
        endcase

        // registered strobes follow the next phase so the pins never glitch
        d.ras_n = !(d.ph inside {S_RCD, S_COL, S_CAS, S_CBRR});
        d.cas_n = !(d.ph inside {S_CAS, S_CBRC, S_CBRR});
        d.addr  = (d.ph inside {S_COL, S_CAS}) ? d.col : d.row;
        d.oe_n  = !(d.op == OP_RD && d.ph == S_CAS);
        if (LATE_WRITE) begin
            d.we_n  = !(d.op == OP_WR && d.ph == S_CAS && d.tmr != TMR_W'(T_CAS - 1));
            d.dq_oe = (d.op == OP_WR) && (d.ph == S_CAS);
        end else begin
            d.we_n  = !(d.op == OP_WR && d.ph inside {S_COL, S_CAS});
            d.dq_oe = (d.op == OP_WR) && (d.ph inside {S_ROW, S_RCD, S_COL, S_CAS});
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.ph    <= S_PAUSE;
            q.op    <= OP_RF;
            q.tmr   <= TMR_W'(PAUSE_CYC - 1);
            q.wake  <= WK_W'(WAKE_N);
            q.ras_n <= 1'b1;
            q.cas_n <= 1'b1;
            q.we_n  <= 1'b1;
            q.oe_n  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rsp_valid   = q.rsp;
    assign rsp_rdata   = q.rdata;
    assign dram_ras_n  = q.ras_n;
    assign dram_cas_n  = q.cas_n;
    assign dram_we_n   = q.we_n;
    assign dram_oe_n   = q.oe_n;
    assign dram_addr   = q.addr;
    assign dram_dq_out = q.wdata;
    assign dram_dq_oe  = q.dq_oe;
endmodule

// File: rtl/fpm_dram_chk.sv
module fpm_dram_chk #(
    parameter bit LATE_WRITE = 1'b0
) (
    input logic clk,
    input logic rst_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic oe_n,
    input logic dq_oe,
    input logic ready,
    input logic rsp_valid
);
    // R3
    cbr_we_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && $fell(ras_n)) |-> we_n);

    // R5
    we_low_oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> oe_n);

    // R5
    drive_oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> oe_n);

    // R10
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (ras_n && cas_n));

    // R6
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R6
    read_we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && !cas_n) |=> (we_n || (ras_n && cas_n)));

    generate
        if (LATE_WRITE) begin : g_late
            // R5
            late_we_after_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(we_n) |-> (!cas_n && !$past(cas_n)));
        end else begin : g_early
            // R4
            early_we_before_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(we_n) |-> cas_n);
        end
    endgenerate
endmodule

bind fpm_dram_ctrl fpm_dram_chk #(.LATE_WRITE(LATE_WRITE)) u_fpm_dram_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_n     (dram_ras_n),
    .cas_n     (dram_cas_n),
    .we_n      (dram_we_n),
    .oe_n      (dram_oe_n),
    .dq_oe     (dram_dq_oe),
    .ready     (req_ready),
    .rsp_valid (rsp_valid)
);

// File: tb/fpm_dram_model.sv
module fpm_dram_model #(
    parameter int ADDR_W  = 4,
    parameter int DQ_W    = 4,
    parameter bit LATE    = 1'b0,
    parameter int T_RP    = 2,
    parameter int GAP_MAX = 80
) (
    input  logic              clk,
    input  logic              active,
    input  logic              is_write,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              dq_oe,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   dq_out,
    output logic [DQ_W-1:0]   dq_in
);
    logic [DQ_W-1:0] mem [0:(1<<(2*ADDR_W))-1];
    logic [ADDR_W-1:0] row = '0, col = '0;
    int checks = 0, fails = 0, refreshes = 0, falls = 0;
    logic p_ras = 1'b1, p_cas = 1'b1, in_cbr = 1'b0, in_read = 1'b0, wrote = 1'b0, have_ref = 1'b0;
    int hi_cnt = 0, gap = 0;

    initial for (int i = 0; i < (1<<(2*ADDR_W)); i++) mem[i] = '0;

    assign dq_in = (!oe_n && !cas_n && !ras_n && we_n) ? mem[{row, col}] : '0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s (%s model) actual=%0d expected=%0d at %0t", req, LATE ? "late" : "early", act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        gap++;
        if (!active) have_ref = 1'b0;
        if (p_cas && !cas_n) falls++;
        if (p_ras && !ras_n) falls++;
        if (p_cas && !cas_n && ras_n) begin
            in_cbr = 1'b1;
            chk(we_n, "R3 we during cbr", we_n, 1);
        end
        if (p_ras && !ras_n && !cas_n) begin
            chk(in_cbr, "R3 cas before ras", in_cbr, 1);
            chk(we_n, "R3 we at cbr ras", we_n, 1);
            refreshes++;
            if (active && have_ref) chk(gap <= GAP_MAX, "R7 refresh gap", gap, GAP_MAX);
            have_ref = 1'b1;
            gap = 0;
        end
        if (p_ras && !ras_n && cas_n) begin
            row = addr;
            chk(hi_cnt >= T_RP, "R9 precharge", hi_cnt, T_RP);
        end
        if (p_ras && !ras_n) begin
            if (!in_cbr) chk(hi_cnt >= T_RP, "R9 precharge", hi_cnt, T_RP);
        end
        if (p_cas && !cas_n && !ras_n) begin
            col = addr;
            if (is_write) begin
                if (LATE) chk(we_n, "R5 we high at cas fall", we_n, 1);
                else      chk(!we_n && dq_oe, "R4 we low before cas", we_n, 0);
            end else begin
                in_read = 1'b1;
            end
        end
        if (in_read && !(ras_n && cas_n)) chk(we_n, "R6 we held high in read", we_n, 1);
        if (!ras_n && !cas_n && !we_n && !wrote) begin
            chk(dq_oe && oe_n, "R4/R5 write drive with oe high", {dq_oe, oe_n}, 3);
            mem[{row, col}] = dq_out;
            wrote = 1'b1;
        end
        if (cas_n) wrote = 1'b0;
        if (ras_n && cas_n) begin
            in_cbr  = 1'b0;
            in_read = 1'b0;
        end
        hi_cnt = ras_n ? hi_cnt + 1 : 0;
        p_ras = ras_n;
        p_cas = cas_n;
    end
endmodule

// File: tb/test_fpm_dram_ctrl.sv
`timescale 1ns/1ps
module test_fpm_dram_ctrl;
    localparam int AW = 4, DW = 4, PAUSE = 40, TRP = 2, RINT = 60, RLIM = 400;
    localparam int GAPMAX = RINT + 20;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, ref_inhibit = 1'b0, active = 1'b0;
    logic [2*AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic rdy_e, rdy_l, rv_e, rv_l;
    logic [DW-1:0] rd_e, rd_l;
    logic ras_e, cas_e, we_e, oe_e, dqoe_e, ras_l, cas_l, we_l, oe_l, dqoe_l;
    logic [AW-1:0] a_e, a_l;
    logic [DW-1:0] dqo_e, dqo_l, dqi_e, dqi_l;
    logic [DW-1:0] shadow [0:(1<<(2*AW))-1];
    int checks = 0, fails = 0, cyc = 0, rsp_e = 0, rsp_l = 0, rd_issued = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fpm_dram_ctrl #(.ADDR_W(AW), .DQ_W(DW), .PAUSE_CYC(PAUSE), .T_RCD(2), .T_CAS(2), .T_RP(TRP),
        .T_CSR(1), .T_RAS(3), .REF_INTERVAL(RINT), .REF_LIMIT(RLIM), .LATE_WRITE(1'b0)) i_fpm_dram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_e), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rv_e), .rsp_rdata(rd_e),
        .ref_inhibit(ref_inhibit), .dram_ras_n(ras_e), .dram_cas_n(cas_e), .dram_we_n(we_e),
        .dram_oe_n(oe_e), .dram_addr(a_e), .dram_dq_out(dqo_e), .dram_dq_oe(dqoe_e), .dram_dq_in(dqi_e));

    fpm_dram_ctrl #(.ADDR_W(AW), .DQ_W(DW), .PAUSE_CYC(PAUSE), .T_RCD(2), .T_CAS(2), .T_RP(TRP),
        .T_CSR(1), .T_RAS(3), .REF_INTERVAL(RINT), .REF_LIMIT(RLIM), .LATE_WRITE(1'b1)) i_fpm_dram_ctrl_late (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_l), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rv_l), .rsp_rdata(rd_l),
        .ref_inhibit(ref_inhibit), .dram_ras_n(ras_l), .dram_cas_n(cas_l), .dram_we_n(we_l),
        .dram_oe_n(oe_l), .dram_addr(a_l), .dram_dq_out(dqo_l), .dram_dq_oe(dqoe_l), .dram_dq_in(dqi_l));

    fpm_dram_model #(.ADDR_W(AW), .DQ_W(DW), .LATE(1'b0), .T_RP(TRP), .GAP_MAX(GAPMAX)) m_e (
        .clk(clk), .active(active), .is_write(req_write), .ras_n(ras_e), .cas_n(cas_e), .we_n(we_e),
        .oe_n(oe_e), .dq_oe(dqoe_e), .addr(a_e), .dq_out(dqo_e), .dq_in(dqi_e));
    fpm_dram_model #(.ADDR_W(AW), .DQ_W(DW), .LATE(1'b1), .T_RP(TRP), .GAP_MAX(GAPMAX)) m_l (
        .clk(clk), .active(active), .is_write(req_write), .ras_n(ras_l), .cas_n(cas_l), .we_n(we_l),
        .oe_n(oe_l), .dq_oe(dqoe_l), .addr(a_l), .dq_out(dqo_l), .dq_in(dqi_l));

    function automatic logic [AW-1:0] exp_row(input logic [2*AW-1:0] a);
        return a[2*AW-1:AW];
    endfunction
    function automatic logic [AW-1:0] exp_col(input logic [2*AW-1:0] a);
        return a[AW-1:0];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***",
                 checks + m_e.checks + m_l.checks, fails + m_e.fails + m_l.fails);
    endtask

    always @(negedge clk) begin
        if (rv_e) rsp_e++;
        if (rv_l) rsp_l++;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    task automatic wait_ready();
        @(negedge clk);
        while (!rdy_e) @(negedge clk);
    endtask

    task automatic do_op(input bit wr, input logic [2*AW-1:0] a, input logic [DW-1:0] dat);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = dat;
        while (!rdy_e) @(negedge clk);
        chk(rdy_l == rdy_e && ras_e && cas_e, "R10 ready only when idle", {rdy_l, ras_e, cas_e}, 7);
        @(negedge clk);
        req_valid = 1'b0;
        if (wr) begin
            shadow[a] = dat;
            wait_ready();
        end else begin
            rd_issued++;
            while (!rv_e) @(negedge clk);
            chk(rd_e == shadow[a], "R10 read data early", rd_e, shadow[a]);
            chk(rv_l && rd_l == shadow[a], "R10 read data late", rd_l, shadow[a]);
            wait_ready();
        end
        chk(m_e.row == exp_row(a) && m_e.col == exp_col(a), "R9 row/col early", {m_e.row, m_e.col}, a);
        chk(m_l.row == exp_row(a) && m_l.col == exp_col(a), "R9 row/col late", {m_l.row, m_l.col}, a);
    endtask

    initial begin
        int c0, t;
        void'($urandom(32'd20240517));
        for (int i = 0; i < (1<<(2*AW)); i++) shadow[i] = '0;
        repeat (4) @(negedge clk);
        // reset state (R1)
        chk(ras_e && cas_e && !rdy_e, "R1 reset state", {ras_e, cas_e, rdy_e}, 6);
        rst_n = 1'b1;
        repeat (PAUSE) @(negedge clk);
        chk(m_e.falls == 0 && m_l.falls == 0 && !rdy_e, "R1 pause holds strobes idle", m_e.falls, 0);
        t = 0;
        while (!rdy_e && t < 2000) begin @(negedge clk); t++; end
        chk(m_e.refreshes == 8, "R2 wake-up refresh count early", m_e.refreshes, 8);
        chk(m_l.refreshes == 8, "R2 wake-up refresh count late", m_l.refreshes, 8);
        active = 1'b1;

        // directed corners
        do_op(1'b1, '0, 4'h5);
        do_op(1'b0, '0, '0);
        do_op(1'b1, '1, 4'hA);
        do_op(1'b0, '1, '0);
        do_op(1'b1, {{AW{1'b1}}, {AW{1'b0}}}, 4'hF);
        do_op(1'b0, {{AW{1'b1}}, {AW{1'b0}}}, '0);
        do_op(1'b0, {{AW{1'b0}}, {AW{1'b1}}}, '0);

        // random traffic, refresh priority and gap (R7)
        c0 = m_e.refreshes;
        for (int n = 0; n < 400; n++) begin
            logic [2*AW-1:0] ra;
            ra = (2*AW)'($urandom);
            do_op(($urandom % 2) == 1, ra, DW'($urandom));
        end
        chk(m_e.refreshes > c0, "R7 refresh under traffic", m_e.refreshes, c0 + 1);
        chk(m_e.refreshes == m_l.refreshes, "R7 equal refresh counts", m_l.refreshes, m_e.refreshes);

        // inhibit defers periodic refresh (R11)
        active = 1'b0;
        wait_ready();
        ref_inhibit = 1'b1;
        c0 = m_e.refreshes;
        repeat (150) @(negedge clk);
        chk(m_e.refreshes == c0, "R11 refresh deferred", m_e.refreshes, c0);
        chk(rdy_e == 1'b1, "R11 ready while deferred", rdy_e, 1);
        ref_inhibit = 1'b0;
        repeat (12) @(negedge clk);
        chk(m_e.refreshes == c0 + 1, "R11 deferred refresh runs", m_e.refreshes, c0 + 1);

        // overrun repeats wake-up (R8)
        wait_ready();
        ref_inhibit = 1'b1;
        c0 = m_e.refreshes;
        t = 0;
        while (rdy_e && t < 1000) begin @(negedge clk); t++; end
        chk(t < 1000, "R8 ready drops on overrun", t, RLIM);
        wait_ready();
        chk(m_e.refreshes - c0 == 8, "R8 rewake count early", m_e.refreshes - c0, 8);
        chk(m_l.refreshes - c0 == 8, "R8 rewake count late", m_l.refreshes - c0, 8);
        ref_inhibit = 1'b0;
        active = 1'b1;
        do_op(1'b0, '1, '0);
        do_op(1'b0, '0, '0);

        repeat (10) @(negedge clk);
        chk(rsp_e == rd_issued && rsp_l == rd_issued, "R6 one rsp pulse per read", rsp_e, rd_issued);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule